// File: doc/BRIEF.md
# Store-Conditional Word Unit

This block carries out the conditional half of a load-reserve / store-conditional pair for a 32-bit core. It decodes a single instruction word, presents the three register indices it names, and adds the two address operands that come back to form the target address. It then decides between three outcomes. If no reservation is held, the store is dropped. If address translation is active and the external MMU stub reports a miss or a denial, a data exception is taken. Otherwise a word write is issued on a valid/ready bus.

Success or failure is reported through a carry flag rather than a fault. With the exclusive-bus option active for an access, a write that the slave does not answer with exclusive-okay also counts as a failure. The reservation is armed by a one-cycle input pulse and is cleared whenever a write completes, whatever the outcome. The block also keeps the exception-status fields and the mode bits (user mode, translation mode and their saved copies) that the exception path updates.

Top module: `store_cond_unit`

## Requirements
- R1: An instruction is executed only when instr[31:26] = 6'b110110 and instr[10:0] = 11'b100_0000_0000. Any other word raises no done pulse and changes no flag, status field or bus output. The register indices are rd_sel = instr[25:21], ra_sel = instr[20:16] and rb_sel = instr[15:11], presented combinationally.
- R2: The write address is ra_val + rb_val, and the write data is rd_val. The two low address bits are passed through unchanged, and no alignment exception is ever raised.
- R3: If an accepted instruction finds the reservation clear, no write is issued and no exception is raised, whatever the MMU inputs say. In the next cycle done = 1 and carry = 1.
- R4: If the reservation is set, msr_vm = 1 and tlb_miss = 1, an exception is taken. In the next cycle done = 1, exc_valid = 1, exc_code = 5'b10010 and esr_store = 1; esr_noacc keeps its value. A miss takes priority over a denial.
- R5: If the reservation is set, msr_vm = 1, tlb_miss = 0 and prot_deny = 1, an exception is taken with exc_code = 5'b10000 and esr_store = 1. esr_noacc takes prot_noacc: 1 for a no-access zone, 0 for a read-only zone.
- R6: On either exception, msr_ums takes msr_um and msr_vms takes msr_vm; msr_um and msr_vm are then cleared. The reservation and carry are left unchanged and no write is issued.
- R7: When msr_vm = 0, tlb_miss and prot_deny have no effect. A reserved store raises wr_valid in the cycle after issue and holds it, with its address and data, until wr_ready. In the cycle after the handshake, wr_valid = 0, done = 1 and the reservation is clear.
- R8: The carry flag is taken at the handshake. It is 1 when wr_excl = 1 (taken from excl_en at issue) and wr_resp differs from 2'b01 (exclusive-okay); otherwise it is 0. Responses 2'b00 (okay) and 2'b10 (slave error) on a non-exclusive write therefore give carry = 0.
- R9: A resv_set pulse sets the reservation in the next cycle, and it wins over a completion clear in the same cycle.
- R10: While a write is outstanding, further issue pulses are ignored.
- R11: After reset all flags, status fields, mode bits, done and wr_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction word valid this cycle |
| instr | input | 32 | Instruction word |
| rd_sel | output | 5 | Index of the data register |
| ra_sel | output | 5 | Index of the first address register |
| rb_sel | output | 5 | Index of the second address register |
| rd_val | input | DW | Value of the data register |
| ra_val | input | AW | Value of the first address register |
| rb_val | input | AW | Value of the second address register |
| resv_set | input | 1 | Pulse that arms the reservation |
| mode_wr | input | 1 | Load msr_um and msr_vm from mode_um and mode_vm |
| mode_um | input | 1 | User-mode value to load |
| mode_vm | input | 1 | Translation-mode value to load |
| tlb_miss | input | 1 | MMU stub: no translation for the address |
| prot_deny | input | 1 | MMU stub: access denied by zone protection |
| prot_noacc | input | 1 | MMU stub: the denial is from a no-access zone |
| excl_en | input | 1 | Exclusive-bus mode applies to this address |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_excl | output | 1 | Write is an exclusive access |
| wr_ready | input | 1 | Slave accepts the write and returns its response |
| wr_resp | input | 2 | Response: 00 okay, 01 exclusive-okay, 10 slave error |
| done | output | 1 | One-cycle completion pulse |
| exc_valid | output | 1 | The completion was an exception |
| carry | output | 1 | 1 when the store failed |
| exc_code | output | 5 | Exception code |
| esr_store | output | 1 | The exception came from a store |
| esr_noacc | output | 1 | The denial came from a no-access zone |
| msr_um | output | 1 | User mode |
| msr_vm | output | 1 | Translation mode |
| msr_ums | output | 1 | Saved user mode |
| msr_vms | output | 1 | Saved translation mode |
| resv | output | 1 | Reservation flag |

## Verification
The assertions rely on three things about the inputs. mode_wr is never pulsed in the cycle of an accepted issue. prot_noacc is raised only with prot_deny and only while msr_um = 1. wr_resp is stable whenever wr_ready is high. The stimulus keeps to these rules in every case: mode changes go through a separate task that runs between operations, and the slave model drives the response from a per-case setting before it raises ready. Every other behaviour is stepped by a behavioural model of the flags and the bus, which is compared with the outputs on each clock.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned EC_W  = 5;
  localparam logic [5:0]  OPC_SC     = 6'b110110;
  localparam logic [10:0] FUNC_SC    = 11'b100_0000_0000;
  localparam logic [EC_W-1:0] EC_TLB  = 5'b10010;
  localparam logic [EC_W-1:0] EC_PROT = 5'b10000;
  localparam logic [1:0]  RESP_OKAY   = 2'b00;
  localparam logic [1:0]  RESP_EXOKAY = 2'b01;
  localparam logic [1:0]  RESP_SLVERR = 2'b10;

  typedef enum logic {ST_IDLE = 1'b0, ST_WRITE = 1'b1} sc_state_e;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [31:0]      instr,
  input  logic [AW-1:0]    ra_val,
  input  logic [AW-1:0]    rb_val,
  output logic             hit,
  output logic [IDX_W-1:0] rd_sel,
  output logic [IDX_W-1:0] ra_sel,
  output logic [IDX_W-1:0] rb_sel,
  output logic [AW-1:0]    ea
);
  always_comb begin
    hit    = (instr[31:26] == OPC_SC) && (instr[10:0] == FUNC_SC);
    rd_sel = instr[25:21];
    ra_sel = instr[20:16];
    rb_sel = instr[15:11];
    // no alignment check: low bits pass straight through
    ea     = ra_val + rb_val;
  end
endmodule

// File: rtl/sc_reservation.sv
module sc_reservation (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic resv
);
  always_ff @(posedge clk) begin
    if (rst)      resv <= 1'b0;
    else if (set) resv <= 1'b1;
    else if (clr) resv <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set |=> resv);
endmodule

// File: rtl/sc_status.sv
module sc_status
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_wr,
  input  logic            mode_um,
  input  logic            mode_vm,
  input  logic            take_exc,
  input  logic [EC_W-1:0] code_in,
  input  logic            noacc_we,
  input  logic            noacc_in,
  output logic            um,
  output logic            vm,
  output logic            ums,
  output logic            vms,
  output logic [EC_W-1:0] code,
  output logic            st_bit,
  output logic            noacc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      um <= 1'b0; vm <= 1'b0; ums <= 1'b0; vms <= 1'b0;
      code <= '0; st_bit <= 1'b0; noacc <= 1'b0;
    end else if (take_exc) begin
      ums    <= um;
      vms    <= vm;
      um     <= 1'b0;
      vm     <= 1'b0;
      code   <= code_in;
      st_bit <= 1'b1;
      if (noacc_we) noacc <= noacc_in;
    end else if (mode_wr) begin
      um <= mode_um;
      vm <= mode_vm;
    end
  end

  assert_exc_modes_R6: assert property (@(posedge clk) disable iff (rst)
    take_exc |=> (!um && !vm && st_bit && ums == $past(um) && vms == $past(vm)));
endmodule

// File: rtl/store_cond_unit.sv
module store_cond_unit
  import sc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [31:0]      instr,
  output logic [IDX_W-1:0] rd_sel,
  output logic [IDX_W-1:0] ra_sel,
  output logic [IDX_W-1:0] rb_sel,
  input  logic [DW-1:0]    rd_val,
  input  logic [AW-1:0]    ra_val,
  input  logic [AW-1:0]    rb_val,
  input  logic             resv_set,
  input  logic             mode_wr,
  input  logic             mode_um,
  input  logic             mode_vm,
  input  logic             tlb_miss,
  input  logic             prot_deny,
  input  logic             prot_noacc,
  input  logic             excl_en,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             wr_excl,
  input  logic             wr_ready,
  input  logic [1:0]       wr_resp,
  output logic             done,
  output logic             exc_valid,
  output logic             carry,
  output logic [EC_W-1:0]  exc_code,
  output logic             esr_store,
  output logic             esr_noacc,
  output logic             msr_um,
  output logic             msr_vm,
  output logic             msr_ums,
  output logic             msr_vms,
  output logic             resv
);
  sc_state_e       state;
  logic            dec_hit;
  logic [AW-1:0]   ea;
  logic            go, nores, exc_tlb, exc_prot, take_exc, start_wr, accept;
  logic [EC_W-1:0] exc_code_nx;

  sc_decode #(.AW(AW)) u_dec (
    .instr(instr), .ra_val(ra_val), .rb_val(rb_val),
    .hit(dec_hit), .rd_sel(rd_sel), .ra_sel(ra_sel), .rb_sel(rb_sel), .ea(ea)
  );

  always_comb begin
    go          = (state == ST_IDLE) && issue && dec_hit;
    nores       = go && !resv;
    exc_tlb     = go && resv && msr_vm && tlb_miss;
    exc_prot    = go && resv && msr_vm && !tlb_miss && prot_deny;
    take_exc    = exc_tlb || exc_prot;
    start_wr    = go && resv && !take_exc;
    accept      = (state == ST_WRITE) && wr_ready;
    exc_code_nx = exc_tlb ? EC_TLB : EC_PROT;
  end

  sc_reservation u_resv (
    .clk(clk), .rst(rst), .set(resv_set), .clr(accept), .resv(resv)
  );

  sc_status u_stat (
    .clk(clk), .rst(rst),
    .mode_wr(mode_wr), .mode_um(mode_um), .mode_vm(mode_vm),
    .take_exc(take_exc), .code_in(exc_code_nx),
    .noacc_we(exc_prot), .noacc_in(prot_noacc),
    .um(msr_um), .vm(msr_vm), .ums(msr_ums), .vms(msr_vms),
    .code(exc_code), .st_bit(esr_store), .noacc(esr_noacc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_excl   <= 1'b0;
      done      <= 1'b0;
      exc_valid <= 1'b0;
      carry     <= 1'b0;
    end else begin
      done      <= nores || take_exc || accept;
      exc_valid <= take_exc;
      if (start_wr) begin
        state   <= ST_WRITE;
        wr_addr <= ea;
        wr_data <= rd_val;
        wr_excl <= excl_en;
      end else if (accept) begin
        state   <= ST_IDLE;
      end
      if (nores)
        carry <= 1'b1;
      else if (accept)
        carry <= wr_excl && (wr_resp != RESP_EXOKAY);
    end
  end

  assign wr_valid = (state == ST_WRITE);

  assert_ignore_R1: assert property (@(posedge clk) disable iff (rst)
    (issue && !dec_hit && !wr_valid) |=> (!done && !wr_valid));
  assert_nores_fail_R3: assert property (@(posedge clk) disable iff (rst)
    nores |=> (carry && done && !exc_valid && !wr_valid));
  assert_exc_code_R5: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (done && esr_store && (exc_code == EC_TLB || exc_code == EC_PROT)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_complete_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && !resv_set) |=> (!resv && done && !wr_valid));
  assert_excl_fail_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_excl && wr_resp != RESP_EXOKAY) |=> carry);
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> !done);
endmodule

// File: tb/test_store_cond_unit.sv
module test_store_cond_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 0, resv_set = 0, mode_wr = 0, mode_um = 0, mode_vm = 0;
  logic        tlb_miss = 0, prot_deny = 0, prot_noacc = 0, excl_en = 0;
  logic [31:0] instr = '0;
  logic [4:0]  rd_sel, ra_sel, rb_sel;
  logic [31:0] rd_val, ra_val, rb_val;
  logic        wr_valid, wr_excl, wr_ready = 0;
  logic [31:0] wr_addr, wr_data;
  logic [1:0]  wr_resp = 2'b00;
  logic        done, exc_valid, carry, esr_store, esr_noacc;
  logic [4:0]  exc_code;
  logic        msr_um, msr_vm, msr_ums, msr_vms, resv;

  always #10 clk = ~clk;

  store_cond_unit i_store_cond_unit (.*);

  int compared = 0, mismatched = 0;
  logic [31:0] rf [32];
  logic [31:0] mem [logic [31:0]];

  assign rd_val = rf[instr[25:21]];
  assign ra_val = rf[instr[20:16]];
  assign rb_val = rf[instr[15:11]];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int rd, input int ra, input int rb);
    return {6'b110110, 5'(rd), 5'(ra), 5'(rb), 11'b100_0000_0000};
  endfunction

  // behavioural reference model, stepped on every clock
  bit started = 0;
  bit m_resv, m_um, m_vm, m_ums, m_vms, m_carry, m_s, m_noacc, m_done, m_exc;
  bit m_busy, m_excl;
  logic [4:0]  m_code;
  logic [31:0] m_addr, m_data;

  always @(posedge clk) begin
    bit clr, hit;
    started = 1;
    clr = 0;
    if (rst) begin
      m_resv = 0; m_um = 0; m_vm = 0; m_ums = 0; m_vms = 0; m_carry = 0;
      m_s = 0; m_noacc = 0; m_done = 0; m_exc = 0; m_busy = 0; m_excl = 0;
      m_code = 0; m_addr = 0; m_data = 0;
    end else begin
      hit = (instr[31:26] == 6'b110110) && (instr[10:0] == 11'h400);
      m_done = 0; m_exc = 0;
      if (m_busy) begin
        if (wr_ready) begin
          if (!m_excl || wr_resp == 2'b01) mem[m_addr] = m_data;
          m_carry = m_excl && (wr_resp != 2'b01);
          clr = 1; m_busy = 0; m_done = 1;
        end
      end else if (issue && hit) begin
        if (!m_resv) begin
          m_carry = 1; m_done = 1;
        end else if (m_vm && (tlb_miss || prot_deny)) begin
          m_code = tlb_miss ? 5'b10010 : 5'b10000;
          if (!tlb_miss) m_noacc = prot_noacc;
          m_s = 1; m_ums = m_um; m_vms = m_vm; m_um = 0; m_vm = 0;
          m_done = 1; m_exc = 1;
        end else begin
          m_busy = 1; m_excl = excl_en;
          m_addr = rf[instr[20:16]] + rf[instr[15:11]];
          m_data = rf[instr[25:21]];
        end
      end
      if (mode_wr && !m_exc) begin m_um = mode_um; m_vm = mode_vm; end
      if (resv_set) m_resv = 1; else if (clr) m_resv = 0;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(done == m_done, "R3", "done", done, m_done);
      chk(exc_valid == m_exc, "R4", "exc_valid", exc_valid, m_exc);
      chk(carry == m_carry, "R8", "carry", carry, m_carry);
      chk(exc_code == m_code, "R5", "exc_code", exc_code, m_code);
      chk(esr_store == m_s, "R4", "esr_store", esr_store, m_s);
      chk(esr_noacc == m_noacc, "R5", "esr_noacc", esr_noacc, m_noacc);
      chk({msr_um, msr_vm, msr_ums, msr_vms} == {m_um, m_vm, m_ums, m_vms},
          "R6", "mode bits", {msr_um, msr_vm, msr_ums, msr_vms}, {m_um, m_vm, m_ums, m_vms});
      chk(resv == m_resv, "R9", "resv", resv, m_resv);
      chk(wr_valid == m_busy, "R7", "wr_valid", wr_valid, m_busy);
      if (m_busy) begin
        chk(wr_addr == m_addr, "R2", "wr_addr", wr_addr, m_addr);
        chk(wr_data == m_data, "R2", "wr_data", wr_data, m_data);
        chk(wr_excl == m_excl, "R8", "wr_excl", wr_excl, m_excl);
      end
      chk({rd_sel, ra_sel, rb_sel} == instr[25:11], "R1", "selects",
          {rd_sel, ra_sel, rb_sel}, instr[25:11]);
    end
  end

  // write slave
  int ready_dly = 0, wcnt = 0;
  bit set_on_accept = 0;
  always @(negedge clk) begin
    #2;
    if (!wr_valid) begin
      wcnt = 0; wr_ready = 0; resv_set = set_on_accept ? 1'b0 : resv_set;
    end else begin
      wr_ready = (wcnt >= ready_dly);
      if (set_on_accept) resv_set = wr_ready;
      wcnt++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
      summary();
    end
  end

  task automatic arm();
    @(negedge clk); #1 resv_set = 1;
    @(negedge clk); #1 resv_set = 0;
  endtask

  task automatic set_mode(input bit um, input bit vm);
    @(negedge clk); #1 mode_wr = 1; mode_um = um; mode_vm = vm;
    @(negedge clk); #1 mode_wr = 0;
  endtask

  task automatic run(input logic [31:0] iw, input bit ex, input bit tm,
                     input bit pd, input bit na, input int lim, output bit seen);
    int n = 0;
    @(negedge clk); #1;
    instr = iw; issue = 1; excl_en = ex; tlb_miss = tm; prot_deny = pd; prot_noacc = na;
    @(negedge clk);
    seen = done;
    #1 issue = 0; tlb_miss = 0; prot_deny = 0; prot_noacc = 0;
    while (!seen && n < lim) begin
      @(negedge clk); seen = done; n++;
    end
  endtask

  initial begin
    bit seen;
    logic [31:0] a;
    for (int i = 0; i < 32; i++) rf[i] = 32'h2000_0000 + i * 32'h104;
    rf[1] = 32'h3;
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk({done, exc_valid, carry, resv, wr_valid, msr_um, msr_vm, esr_store} == 8'h0,
        "R11", "reset state", {done, exc_valid, carry, resv, wr_valid, msr_um, msr_vm, esr_store}, 0);

    // R3: no reservation, MMU inputs set but ignored
    set_mode(1, 1);
    run(mk(2, 3, 4), 0, 1, 1, 1, 6, seen);
    chk(seen && carry && !exc_valid, "R3", "nores fail", {seen, carry, exc_valid}, 3'b110);
    chk(msr_vm == 1, "R3", "vm kept", msr_vm, 1);

    // R1: wrong opcode and wrong function bits ignored
    set_mode(0, 0);
    arm();
    run(mk(2, 3, 4) ^ 32'h0400_0000, 0, 0, 0, 0, 6, seen);
    chk(!seen, "R1", "bad opcode no done", seen, 0);
    run(mk(2, 3, 4) | 32'h1, 0, 0, 0, 0, 6, seen);
    chk(!seen && resv, "R1", "bad func ignored", {seen, resv}, 2'b01);

    // R7: plain write with delay, R6 flags ignored with vm=0
    ready_dly = 2; wr_resp = 2'b00;
    run(mk(5, 6, 7), 0, 1, 1, 0, 20, seen);
    a = rf[6] + rf[7];
    chk(seen && !carry && !resv && !exc_valid, "R7", "write ok",
        {seen, carry, resv, exc_valid}, 4'b1000);
    chk(mem.exists(a) && mem[a] == rf[5], "R7", "memory", mem.exists(a) ? mem[a] : 0, rf[5]);

    // R8: exclusive with exclusive-okay
    arm(); ready_dly = 0; wr_resp = 2'b01;
    run(mk(8, 9, 10), 1, 0, 0, 0, 20, seen);
    a = rf[9] + rf[10];
    chk(!carry && mem.exists(a), "R8", "exokay stores", carry, 0);

    // R8: exclusive with plain okay fails
    arm(); wr_resp = 2'b00;
    run(mk(11, 12, 13), 1, 0, 0, 0, 20, seen);
    a = rf[12] + rf[13];
    chk(carry && !mem.exists(a) && !resv, "R8", "excl okay fails",
        {carry, mem.exists(a), resv}, 3'b100);

    // R8: non-exclusive slave error still succeeds
    arm(); wr_resp = 2'b10;
    run(mk(14, 15, 16), 0, 0, 0, 0, 20, seen);
    chk(!carry, "R8", "slverr non-excl", carry, 0);

    // R2: unaligned address
    arm(); wr_resp = 2'b00;
    run(mk(17, 1, 0), 0, 0, 0, 0, 20, seen);
    a = rf[1] + rf[0];
    chk(mem.exists(a) && a[1:0] == 2'b11, "R2", "unaligned write", a[1:0], 2'b11);

    // R4: TLB miss (also with denial: miss wins)
    set_mode(1, 1); arm();
    run(mk(2, 3, 4), 0, 1, 1, 1, 6, seen);
    chk(exc_valid && exc_code == 5'b10010 && esr_store && !esr_noacc, "R4", "tlb exc",
        {exc_valid, exc_code, esr_store, esr_noacc}, {1'b1, 5'b10010, 2'b10});
    chk(msr_ums && msr_vms && !msr_um && !msr_vm && resv, "R6", "saved modes",
        {msr_ums, msr_vms, msr_um, msr_vm, resv}, 5'b11001);

    // R5: no-access denial in user mode
    set_mode(1, 1);
    run(mk(2, 3, 4), 0, 0, 1, 1, 6, seen);
    chk(exc_code == 5'b10000 && esr_noacc, "R5", "noacc exc", {exc_code, esr_noacc}, {5'b10000, 1'b1});

    // R5: read-only denial in kernel mode
    set_mode(0, 1);
    run(mk(2, 3, 4), 0, 0, 1, 0, 6, seen);
    chk(exc_code == 5'b10000 && !esr_noacc && !msr_ums && msr_vms, "R5", "readonly exc",
        {exc_code, esr_noacc, msr_ums, msr_vms}, {5'b10000, 3'b001});

    // R9: set in the completion cycle keeps the reservation
    set_mode(0, 0);
    ready_dly = 1; set_on_accept = 1;
    run(mk(18, 19, 20), 0, 0, 0, 0, 20, seen);
    @(negedge clk);
    chk(resv, "R9", "set wins", resv, 1);
    set_on_accept = 0;

    // R10: issue while busy ignored
    ready_dly = 5;
    @(negedge clk); #1 instr = mk(21, 22, 23); issue = 1;
    @(negedge clk); #1 instr = mk(24, 25, 26);
    @(negedge clk); #1 issue = 0;
    repeat (8) @(negedge clk);
    a = rf[25] + rf[26];
    chk(!mem.exists(a), "R10", "busy issue ignored", mem.exists(a), 0);
    a = rf[22] + rf[23];
    chk(mem.exists(a), "R10", "first write done", mem.exists(a), 1);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule